// File: doc/BRIEF.md
# Secure Floating-Point Access Gate

This block holds three control registers and decides whether a floating-point operation issued by non-secure software must trap. The first register is a gate register that only secure software can write. The second is a coprocessor access register. The third is a hypervisor trap register. A single enable bit in the gate register opens or closes floating-point use for the non-secure world.

While the gate is closed, a field in each of the other two registers is overridden:

- The coprocessor-access field reads as zero and ignores writes.
- The hypervisor-trap field reads as all ones and ignores writes.

The stored bits under these fields are never changed by the override. Opening the gate again exposes them exactly as they were.

Software reaches the registers through a plain synchronous port with a select, a write strobe, write data and read data. Side inputs describe the context of the current access:

- the security state;
- the current exception level (0 to 3);
- whether the highest exception level exists;
- whether that highest level runs in 32-bit mode.

The gate is honoured only when the highest level exists and runs in 32-bit mode. When a floating-point request arrives and the gate conditions hold, the block raises a trap and names the level that takes it.

Top module: `fp_gate_ctrl`

## Requirements
- R1: After reset, all three registers read as zero, and no trap is raised.
- R2: The gate register (select 0) is written only when `in_secure` is 1. A non-secure write leaves it unchanged.
- R3: The gate is active only when all of the following hold: `top_el_present` is 1, `top_el_32bit` is 1, `in_secure` is 0, and bit 10 of the gate register is 0. In every other case, reads and writes of the other registers are unmasked.
- R4: While the gate is active, reading the coprocessor access register (select 1) returns bits [23:20] as zero. All other bits return their stored value, in the same cycle as the select.
- R5: While the gate is active, a write to the coprocessor access register keeps the stored bits [23:20] and takes the write data in all other bits. The kept bits reappear on reads once the gate is lifted.
- R6: While the gate is active, reading the hypervisor trap register (select 2) returns bits [11:10] as ones. Its stored bits reappear unchanged when the gate is lifted.
- R7: The hypervisor trap register is written only when `cur_el` is 2 or 3. While the gate is active, a write to it keeps its stored bits [11:10].
- R8: A floating-point request (`fp_req`) at level 0 or 1 with the gate active raises `fp_trap` in the same cycle, with `fp_trap_el` = 2'b01. A request at level 2 raises it with `fp_trap_el` = 2'b10.
- R9: No trap is raised, and `fp_trap_el` stays 2'b00, in any of these cases: the access is secure, the level is 3, the highest level is absent or runs in 64-bit mode, or gate bit 10 is 1.
- R10: The coprocessor access register is written only when `cur_el` is not 0. Select 3 reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 gate, 1 coprocessor access, 2 hypervisor trap, 3 unmapped |
| reg_we | input | 1 | Write strobe, applied on the next rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Masked read data for the selected register |
| in_secure | input | 1 | Current access is from secure state |
| cur_el | input | 2 | Current exception level |
| top_el_present | input | 1 | Highest exception level is implemented |
| top_el_32bit | input | 1 | Highest exception level runs in 32-bit mode |
| fp_req | input | 1 | A floating-point operation is being attempted |
| fp_trap | output | 1 | The attempted operation must trap |
| fp_trap_el | output | 2 | Level that takes the trap (0 when no trap) |

## Verification
The bound checker watches several properties on every cycle:

- the forced-zero and forced-one read fields while the gate is active;
- that the protected stored fields stay untouched across a gated write;
- that a non-secure write never alters the gate bit;
- the trap target, and the absence of any trap in secure, 64-bit or absent contexts.

Other behaviour shows only across a sequence, so only the bench scenarios demonstrate it:

- stored bits reappearing once the gate opens again;
- other bits of a gated write still landing;
- privilege checks on writes, reset contents, and the whole trap table across all four levels.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [1:0] {
    SEL_GATE  = 2'd0,
    SEL_CPA   = 2'd1,
    SEL_HTRAP = 2'd2,
    SEL_NONE  = 2'd3
  } fpg_sel_e;

  localparam logic [1:0] TRAP_TO_NONE = 2'd0;
  localparam logic [1:0] TRAP_TO_EL1  = 2'd1;
  localparam logic [1:0] TRAP_TO_EL2  = 2'd2;
  localparam logic [1:0] EL_TOP       = 2'd3;

  function automatic logic [1:0] trap_target(input logic [1:0] el);
    return (el == 2'd2) ? TRAP_TO_EL2 : TRAP_TO_EL1;
  endfunction
endpackage

// File: rtl/fpg_guard_reg.sv
module fpg_guard_reg #(
  parameter int DATA_W  = 32,
  parameter int FLD_LO  = 0,
  parameter int FLD_W   = 1,
  parameter bit PROTECT = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              hold_field,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] FLD_MASK =
    ((DATA_W'(1) << FLD_W) - DATA_W'(1)) << FLD_LO;

  logic [DATA_W-1:0] next_val;

  generate
    if (PROTECT) begin : g_prot
      always_comb begin
        if (hold_field) next_val = (wdata & ~FLD_MASK) | (q & FLD_MASK);
        else            next_val = wdata;
      end
    end else begin : g_plain
      logic unused_hold;
      assign unused_hold = hold_field;
      always_comb next_val = wdata;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= next_val;
  end
endmodule

// File: rtl/fpg_gate_eval.sv
module fpg_gate_eval (
  input  logic gate_bit,
  input  logic in_secure,
  input  logic top_el_present,
  input  logic top_el_32bit,
  output logic gate_active
);
  always_comb
    gate_active = top_el_present & top_el_32bit & ~in_secure & ~gate_bit;
endmodule

// File: rtl/fpg_read_mux.sv
module fpg_read_mux
  import fpg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CPA_LO = 20,
  parameter int CPA_W  = 4,
  parameter int HTR_LO = 10,
  parameter int HTR_W  = 2
) (
  input  logic [1:0]        sel,
  input  logic              gate_active,
  input  logic [DATA_W-1:0] gate_q,
  input  logic [DATA_W-1:0] cpa_q,
  input  logic [DATA_W-1:0] htr_q,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [DATA_W-1:0] CPA_MASK =
    ((DATA_W'(1) << CPA_W) - DATA_W'(1)) << CPA_LO;
  localparam logic [DATA_W-1:0] HTR_MASK =
    ((DATA_W'(1) << HTR_W) - DATA_W'(1)) << HTR_LO;

  logic [DATA_W-1:0] cpa_view;
  logic [DATA_W-1:0] htr_view;

  always_comb begin
    cpa_view = gate_active ? (cpa_q & ~CPA_MASK) : cpa_q;
    htr_view = gate_active ? (htr_q | HTR_MASK)  : htr_q;
    case (fpg_sel_e'(sel))
      SEL_GATE:  rdata = gate_q;
      SEL_CPA:   rdata = cpa_view;
      SEL_HTRAP: rdata = htr_view;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/fpg_trap_eval.sv
module fpg_trap_eval
  import fpg_pkg::*;
(
  input  logic       fp_req,
  input  logic       gate_active,
  input  logic [1:0] cur_el,
  output logic       fp_trap,
  output logic [1:0] fp_trap_el
);
  logic low_level;

  always_comb begin
    low_level  = (cur_el != EL_TOP);
    fp_trap    = fp_req & gate_active & low_level;
    fp_trap_el = fp_trap ? trap_target(cur_el) : TRAP_TO_NONE;
  end
endmodule

// File: rtl/fp_gate_ctrl.sv
module fp_gate_ctrl
  import fpg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GATE_BIT = 10,
  parameter int CPA_LO   = 20,
  parameter int CPA_W    = 4,
  parameter int HTR_LO   = 10,
  parameter int HTR_W    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_sel,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              in_secure,
  input  logic [1:0]        cur_el,
  input  logic              top_el_present,
  input  logic              top_el_32bit,
  input  logic              fp_req,
  output logic              fp_trap,
  output logic [1:0]        fp_trap_el
);
  logic [DATA_W-1:0] gate_q, cpa_q, htr_q;
  logic gate_active;
  logic gate_we, cpa_we, htr_we;
  fpg_sel_e sel_e;

  always_comb begin
    sel_e   = fpg_sel_e'(reg_sel);
    gate_we = reg_we & (sel_e == SEL_GATE)  & in_secure;
    cpa_we  = reg_we & (sel_e == SEL_CPA)   & (cur_el != 2'd0);
    htr_we  = reg_we & (sel_e == SEL_HTRAP) & cur_el[1];
  end

  fpg_gate_eval u_gate (
    .gate_bit       (gate_q[GATE_BIT]),
    .in_secure      (in_secure),
    .top_el_present (top_el_present),
    .top_el_32bit   (top_el_32bit),
    .gate_active    (gate_active)
  );

  fpg_guard_reg #(.DATA_W(DATA_W), .FLD_LO(GATE_BIT), .FLD_W(1), .PROTECT(1'b0)) u_gate_reg (
    .clk(clk), .rst(rst), .wr_en(gate_we), .hold_field(1'b0),
    .wdata(reg_wdata), .q(gate_q)
  );

  fpg_guard_reg #(.DATA_W(DATA_W), .FLD_LO(CPA_LO), .FLD_W(CPA_W), .PROTECT(1'b1)) u_cpa_reg (
    .clk(clk), .rst(rst), .wr_en(cpa_we), .hold_field(gate_active),
    .wdata(reg_wdata), .q(cpa_q)
  );

  fpg_guard_reg #(.DATA_W(DATA_W), .FLD_LO(HTR_LO), .FLD_W(HTR_W), .PROTECT(1'b1)) u_htr_reg (
    .clk(clk), .rst(rst), .wr_en(htr_we), .hold_field(gate_active),
    .wdata(reg_wdata), .q(htr_q)
  );

  fpg_read_mux #(
    .DATA_W(DATA_W), .CPA_LO(CPA_LO), .CPA_W(CPA_W),
    .HTR_LO(HTR_LO), .HTR_W(HTR_W)
  ) u_rmux (
    .sel(reg_sel), .gate_active(gate_active),
    .gate_q(gate_q), .cpa_q(cpa_q), .htr_q(htr_q),
    .rdata(reg_rdata)
  );

  fpg_trap_eval u_trap (
    .fp_req(fp_req), .gate_active(gate_active), .cur_el(cur_el),
    .fp_trap(fp_trap), .fp_trap_el(fp_trap_el)
  );
endmodule

// File: rtl/fp_gate_ctrl_chk.sv
module fp_gate_ctrl_chk #(
  parameter int DATA_W = 32,
  parameter int CPA_LO = 20,
  parameter int CPA_W  = 4,
  parameter int HTR_LO = 10,
  parameter int HTR_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_sel,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              in_secure,
  input logic [1:0]        cur_el,
  input logic              top_el_present,
  input logic              top_el_32bit,
  input logic              fp_trap,
  input logic [1:0]        fp_trap_el,
  input logic              gate_bit,
  input logic [CPA_W-1:0]  cpa_field,
  input logic [HTR_W-1:0]  htr_field
);
  logic act;
  assign act = top_el_present && top_el_32bit && !in_secure && !gate_bit;

  // R2
  a_r2_gate_locked: assert property (@(posedge clk) disable iff (rst)
    (!in_secure && reg_we && reg_sel == 2'd0) |=> (gate_bit == $past(gate_bit)));

  // R4
  a_r4_cpa_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (act && reg_sel == 2'd1) |-> (reg_rdata[CPA_LO+CPA_W-1:CPA_LO] == '0));

  // R5
  a_r5_cpa_field_held: assert property (@(posedge clk) disable iff (rst)
    (act && reg_we && reg_sel == 2'd1) |=> $stable(cpa_field));

  // R6
  a_r6_htr_reads_ones: assert property (@(posedge clk) disable iff (rst)
    (act && reg_sel == 2'd2) |-> (reg_rdata[HTR_LO+HTR_W-1:HTR_LO] == '1));

  // R7
  a_r7_htr_field_held: assert property (@(posedge clk) disable iff (rst)
    (act && reg_we && reg_sel == 2'd2) |=> $stable(htr_field));

  // R7
  a_r7_htr_low_el: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel == 2'd2 && cur_el < 2'd2) |=> $stable(htr_field));

  // R8
  a_r8_trap_target: assert property (@(posedge clk) disable iff (rst)
    fp_trap |-> (fp_trap_el == ((cur_el == 2'd2) ? 2'd2 : 2'd1)));

  // R9
  a_r9_no_trap_ctx: assert property (@(posedge clk) disable iff (rst)
    (in_secure || !top_el_present || !top_el_32bit || cur_el == 2'd3 || gate_bit)
      |-> (!fp_trap && fp_trap_el == 2'd0));

  // R10
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_sel == 2'd3) |-> (reg_rdata == '0));
endmodule

bind fp_gate_ctrl fp_gate_ctrl_chk #(
  .DATA_W(DATA_W), .CPA_LO(CPA_LO), .CPA_W(CPA_W), .HTR_LO(HTR_LO), .HTR_W(HTR_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .in_secure(in_secure), .cur_el(cur_el), .top_el_present(top_el_present),
  .top_el_32bit(top_el_32bit), .fp_trap(fp_trap), .fp_trap_el(fp_trap_el),
  .gate_bit(gate_q[GATE_BIT]),
  .cpa_field(cpa_q[CPA_LO+CPA_W-1:CPA_LO]),
  .htr_field(htr_q[HTR_LO+HTR_W-1:HTR_LO])
);

// File: tb/fp_gate_ctrl_test.sv
module fp_gate_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CPA_M = 32'h00F0_0000;
  localparam logic [31:0] HTR_M = 32'h0000_0C00;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        t_sec = 1'b1;
  logic [1:0]  t_el = 2'd3;
  logic        t_pres = 1'b1;
  logic        t_a32 = 1'b1;
  logic        fp_req = 1'b0;
  logic        fp_trap;
  logic [1:0]  fp_trap_el;

  typedef struct {
    bit          is_trap;
    logic [31:0] exp_data;
    logic        exp_trap;
    logic [1:0]  exp_el;
    string       tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] m_gate = '0, m_cpa = '0, m_htr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_gate_ctrl uut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_secure(t_sec),
    .cur_el(t_el), .top_el_present(t_pres), .top_el_32bit(t_a32),
    .fp_req(fp_req), .fp_trap(fp_trap), .fp_trap_el(fp_trap_el)
  );

  function automatic bit m_active();
    return t_pres && t_a32 && !t_sec && !m_gate[10];
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ctx(input bit s, input logic [1:0] e, input bit p, input bit a);
    step();
    reg_we = 1'b0; fp_req = 1'b0;
    t_sec = s; t_el = e; t_pres = p; t_a32 = a;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    step();
    reg_sel = s; reg_we = 1'b1; reg_wdata = d; fp_req = 1'b0;
    case (s)
      2'd0: if (t_sec) m_gate = d;
      2'd1: if (t_el != 2'd0) m_cpa = m_active() ? ((d & ~CPA_M) | (m_cpa & CPA_M)) : d;
      2'd2: if (t_el >= 2'd2) m_htr = m_active() ? ((d & ~HTR_M) | (m_htr & HTR_M)) : d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [1:0] s, input string tag);
    item_t it;
    step();
    reg_sel = s; reg_we = 1'b0; fp_req = 1'b0;
    it.is_trap = 0; it.exp_trap = 0; it.exp_el = 0; it.tag = tag;
    case (s)
      2'd0: it.exp_data = m_gate;
      2'd1: it.exp_data = m_active() ? (m_cpa & ~CPA_M) : m_cpa;
      2'd2: it.exp_data = m_active() ? (m_htr | HTR_M) : m_htr;
      default: it.exp_data = '0;
    endcase
    sb.push_back(it);
  endtask

  task automatic fp(input string tag);
    item_t it;
    step();
    reg_we = 1'b0; fp_req = 1'b1;
    it.is_trap = 1; it.exp_data = '0; it.tag = tag;
    it.exp_trap = m_active() && (t_el != 2'd3);
    it.exp_el = it.exp_trap ? ((t_el == 2'd2) ? 2'd2 : 2'd1) : 2'd0;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      total++;
      if (it.is_trap) begin
        if (fp_trap !== it.exp_trap || fp_trap_el !== it.exp_el) begin
          bad++;
          $display("FAIL %s: trap=%b el=%0d expected trap=%b el=%0d",
                   it.tag, fp_trap, fp_trap_el, it.exp_trap, it.exp_el);
        end
      end else if (reg_rdata !== it.exp_data) begin
        bad++;
        $display("FAIL %s: rdata=%h expected %h", it.tag, reg_rdata, it.exp_data);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset contents and no trap
    rd(2'd0, "R1 gate reset"); rd(2'd1, "R1 cpa reset"); rd(2'd2, "R1 htr reset");
    fp("R1 no trap after reset (secure)");
    // R2 secure write opens gate
    wr(2'd0, 32'h0000_0400);
    rd(2'd0, "R2 secure write");
    ctx(1'b0, 2'd1, 1'b1, 1'b1);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, "R2 non-secure write ignored");
    // open gate: plain writes
    wr(2'd1, 32'h00F0_0F0F);
    rd(2'd1, "R3 cpa unmasked when open");
    wr(2'd2, 32'h0000_0001);
    rd(2'd2, "R7 htr write at el1 ignored");
    ctx(1'b0, 2'd2, 1'b1, 1'b1);
    wr(2'd2, 32'h0000_0001);
    rd(2'd2, "R7 htr write at el2");
    fp("R9 gate bit set no trap");
    // close gate
    ctx(1'b1, 2'd3, 1'b1, 1'b1);
    wr(2'd0, 32'h0000_0000);
    rd(2'd1, "R3 secure read unmasked");
    rd(2'd2, "R3 secure htr unmasked");
    fp("R9 secure el3 no trap");
    ctx(1'b0, 2'd1, 1'b1, 1'b1);
    rd(2'd1, "R4 cpa field zero");
    wr(2'd1, 32'h0000_0003);
    rd(2'd1, "R5 cpa other bits written");
    fp("R8 el1 trap");
    ctx(1'b0, 2'd0, 1'b1, 1'b1);
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, "R10 cpa write at el0 ignored");
    fp("R8 el0 trap to el1");
    ctx(1'b0, 2'd2, 1'b1, 1'b1);
    rd(2'd2, "R6 htr field ones");
    wr(2'd2, 32'h0000_0C00);
    rd(2'd2, "R7 htr gated write");
    fp("R8 el2 trap to el2");
    ctx(1'b0, 2'd3, 1'b1, 1'b1);
    fp("R9 level 3 no trap");
    ctx(1'b0, 2'd1, 1'b1, 1'b0);
    fp("R9 64-bit top no trap");
    rd(2'd1, "R3 64-bit top unmasked");
    ctx(1'b0, 2'd1, 1'b0, 1'b1);
    fp("R9 absent top no trap");
    ctx(1'b1, 2'd1, 1'b1, 1'b1);
    fp("R9 secure el1 no trap");
    // reopen gate: stored fields reappear
    wr(2'd0, 32'h0000_0400);
    ctx(1'b0, 2'd1, 1'b1, 1'b1);
    rd(2'd1, "R5 cpa field reappears");
    rd(2'd2, "R6 htr field reappears");
    fp("R9 reopened no trap");
    wr(2'd3, 32'hDEAD_BEEF);
    rd(2'd3, "R10 unmapped select");
    // literal spot checks of key values
    rd(2'd1, "R5 literal");
    if (m_cpa !== 32'h00F0_0003) begin
      bad++; $display("FAIL R5 model: %h expected 00f00003", m_cpa);
    end
    total++;
    step();
    reg_we = 1'b0; fp_req = 1'b0;
    repeat (3) step();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule